// File: doc/BRIEF.md
# Wide-Register I2C Target

This block is an I2C target that gives a bus host access to a small bank of 56-bit registers. The 7-bit bus address is a 4-bit parameter prefix joined with three strap inputs, so up to seven copies can share one bus. After the address, the host sends a command byte, a fixed base plus a register index, to pick the register. Every register moves as one block of exactly seven bytes, least significant byte first.

Registers 0 and 1 are read-only. Each is sampled from a parallel status input when a read of it begins. Registers 3, 4 and 5 can be written and read back. They drive parallel control outputs. Register 5 is split into four 10-bit current thresholds, each on its own output. SCL and SDA are sampled by the much faster system clock through two-flop synchronizers. SDA is open-drain: the block only pulls it low or releases it.

Top module: `i2c_wide_regbank`

## Requirements
- R1: The block answers to the 7-bit address {ADDR_HI, strap_i}, with ADDR_HI defaulting to 4'h5. It ACKs a matching address byte by pulling SDA low during the ninth clock, and it NACKs any other address.
- R2: While strap_i is 3'b000, the block ACKs no address at all.
- R3: The command byte is CMD_BASE (default 0xE0) plus the register index. Commands for indices 0, 1, 3, 4 and 5 are ACKed. Any other command, for example 0xE2 or 0xE6, is NACKed and ends the transfer.
- R4: A write sends seven data bytes, least significant byte first, each byte MSB first. The register is updated only once the seventh byte is ACKed. ctl3_o and ctl4_o show registers 3 and 4.
- R5: A write with fewer than seven data bytes that is ended by STOP or by a repeated START leaves the register unchanged.
- R6: Indices 0 and 1 are read-only. The first data byte written to them is NACKed and no register changes. A read of them returns stat0_i or stat1_i.
- R7: A read is a command write, a repeated START, the read address, and then seven bytes least significant first. A master ACK moves on to the next byte and a NACK ends the read. Registers 3 to 5 read back the value last written.
- R8: A read-only register is sampled when its read address is accepted. All seven bytes come from that one sample, even if the status input changes during the read.
- R9: Register 5 drives iin_hi_o from bits [9:0], iin_lo_o from [19:10], iout_hi_o from [29:20] and iout_lo_o from [39:30].
- R10: The block starts pulling SDA low only while SCL is low.
- R11: After reset, all control and threshold outputs are zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Low three address bits |
| stat0_i | input | 56 | Status source for register 0 |
| stat1_i | input | 56 | Status source for register 1 |
| ctl3_o | output | 56 | Contents of register 3 |
| ctl4_o | output | 56 | Contents of register 4 |
| iin_hi_o | output | 10 | Input-current high threshold |
| iin_lo_o | output | 10 | Input-current low threshold |
| iout_hi_o | output | 10 | Output-current high threshold |
| iout_lo_o | output | 10 | Output-current low threshold |

## Verification
The hardest case to reach is a status input that changes in the middle of a read. The sample must stay frozen across all seven bytes. The bench runs its own bus-master read one byte at a time. It changes stat1_i after the first byte has been clocked out, expects every byte of that read to carry the old value, and expects a second read to carry the new value. Aborted writes are reached the same way: the master stops after six bytes, or inserts a repeated START after three, and then checks that ctl4_o still shows the earlier value.

// File: rtl/i2c_wide_regbank.sv
module i2c_wide_regbank #(
  parameter logic [3:0] ADDR_HI  = 4'h5,
  parameter logic [7:0] CMD_BASE = 8'hE0,
  parameter int         NBYTES   = 7,
  parameter int         TH_W     = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic [2:0]            strap_i,
  input  logic [8*NBYTES-1:0]   stat0_i,
  input  logic [8*NBYTES-1:0]   stat1_i,
  output logic [8*NBYTES-1:0]   ctl3_o,
  output logic [8*NBYTES-1:0]   ctl4_o,
  output logic [TH_W-1:0]       iin_hi_o,
  output logic [TH_W-1:0]       iin_lo_o,
  output logic [TH_W-1:0]       iout_hi_o,
  output logic [TH_W-1:0]       iout_lo_o
);
  localparam int REG_W = 8 * NBYTES;
  localparam int CW    = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_CMD, ST_WR, ST_RDA, ST_RD, ST_SKIP} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  logic       start_c, stop_c, scl_rise, scl_fall;

  st_t              st;
  logic [3:0]       bitcnt;
  logic             ack_ph, mack;
  logic [7:0]       sr;
  logic [2:0]       cmd_idx;
  logic             cmd_ok;
  logic [CW-1:0]    wcnt, rcnt;
  logic [REG_W-1:0] wbuf, shadow, reg3_q, reg4_q, reg5_q, sel, wnext;
  logic [7:0]       cidx;
  logic             cmd_hit, wr_ok, addr_hit;

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;

  assign cidx     = sr - CMD_BASE;
  assign cmd_hit  = (cidx < 8'd6) && (cidx != 8'd2);
  assign wr_ok    = (cmd_idx == 3'd3) || (cmd_idx == 3'd4) || (cmd_idx == 3'd5);
  assign addr_hit = (sr[7:1] == {ADDR_HI, strap_i}) && (strap_i != 3'd0);
  assign wnext    = {sr, wbuf[REG_W-1:8]};

  always_comb begin
    case (cmd_idx)
      3'd0:    sel = stat0_i;
      3'd1:    sel = stat1_i;
      3'd3:    sel = reg3_q;
      3'd4:    sel = reg4_q;
      default: sel = reg5_q;
    endcase
  end

  assign ctl3_o    = reg3_q;
  assign ctl4_o    = reg4_q;
  assign iin_hi_o  = reg5_q[TH_W-1:0];
  assign iin_lo_o  = reg5_q[2*TH_W-1:TH_W];
  assign iout_hi_o = reg5_q[3*TH_W-1:2*TH_W];
  assign iout_lo_o = reg5_q[4*TH_W-1:3*TH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      ack_ph  <= 1'b0;
      mack    <= 1'b0;
      sr      <= '0;
      cmd_idx <= '0;
      cmd_ok  <= 1'b0;
      wcnt    <= '0;
      rcnt    <= '0;
      wbuf    <= '0;
      shadow  <= '0;
      reg3_q  <= '0;
      reg4_q  <= '0;
      reg5_q  <= '0;
      sda_oe  <= 1'b0;
    end else if (start_c) begin
      st     <= ST_ADDR;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (st == ST_IDLE || st == ST_SKIP) begin
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      if (ack_ph) begin
        mack <= ~sda_s;
      end else if (bitcnt < 4'd8) begin
        sr     <= {sr[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end
    end else if (scl_fall) begin
      if (ack_ph) begin
        ack_ph <= 1'b0;
        bitcnt <= '0;
        if (st == ST_RDA) begin
          st     <= ST_RD;
          sda_oe <= ~shadow[7];
        end else if (st == ST_RD) begin
          if (mack && rcnt < LAST) begin
            shadow <= shadow >> 8;
            sda_oe <= ~shadow[15];
            rcnt   <= rcnt + 1'b1;
          end else begin
            st     <= ST_SKIP;
            sda_oe <= 1'b0;
          end
        end else begin
          sda_oe <= 1'b0;
        end
      end else if (bitcnt == 4'd8) begin
        case (st)
          ST_ADDR: begin
            if (!addr_hit) begin
              st <= ST_SKIP;
            end else if (!sr[0]) begin
              st     <= ST_CMD;
              sda_oe <= 1'b1;
              ack_ph <= 1'b1;
            end else if (cmd_ok) begin
              shadow <= sel;
              rcnt   <= '0;
              st     <= ST_RDA;
              sda_oe <= 1'b1;
              ack_ph <= 1'b1;
            end else begin
              st <= ST_SKIP;
            end
          end
          ST_CMD: begin
            if (cmd_hit) begin
              cmd_idx <= cidx[2:0];
              cmd_ok  <= 1'b1;
              wcnt    <= '0;
              st      <= ST_WR;
              sda_oe  <= 1'b1;
              ack_ph  <= 1'b1;
            end else begin
              cmd_ok <= 1'b0;
              st     <= ST_SKIP;
            end
          end
          ST_WR: begin
            if (wr_ok && wcnt <= LAST) begin
              wbuf   <= wnext;
              wcnt   <= wcnt + 1'b1;
              sda_oe <= 1'b1;
              ack_ph <= 1'b1;
              if (wcnt == LAST) begin
                case (cmd_idx)
                  3'd3:    reg3_q <= wnext;
                  3'd4:    reg4_q <= wnext;
                  default: reg5_q <= wnext;
                endcase
              end
            end else begin
              st <= ST_SKIP;
            end
          end
          ST_RD: begin
            sda_oe <= 1'b0;
            ack_ph <= 1'b1;
          end
          default: st <= ST_SKIP;
        endcase
      end else if (st == ST_RD) begin
        sda_oe <= ~shadow[3'(4'd7 - bitcnt)];
      end
    end
  end

  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s)) else $error("SDA pulled while SCL high"); // R10
  AST_STRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMD && $past(st) == ST_ADDR) |-> ($past(strap_i) != 3'd0)) else $error("address taken with zero strap"); // R2
  AST_WR_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR) |-> cmd_ok) else $error("data phase without command"); // R3
  AST_REG3_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg3_q != $past(reg3_q)) |-> ($past(st) == ST_WR && $past(wcnt) == LAST)) else $error("reg3 changed early"); // R5
  AST_REG4_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg4_q != $past(reg4_q)) |-> ($past(st) == ST_WR && $past(wcnt) == LAST)) else $error("reg4 changed early"); // R4
  AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD) |-> (rcnt <= LAST)) else $error("read past last byte"); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD && $past(st) == ST_RD && $past(rcnt) == rcnt) |-> $stable(shadow)) else $error("snapshot moved"); // R8
endmodule

// File: tb/i2c_wide_regbank_tb.sv
module i2c_wide_regbank_tb_top;
  localparam int Q = 20;
  localparam logic [6:0] A = {4'h5, 3'd3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [2:0] strap = 3'd3;
  logic [55:0] stat0 = 56'hA1B2C3D4E5F607, stat1 = 56'h0F1E2D3C4B5A69;
  logic [55:0] ctl3, ctl4;
  logic [9:0] ihi, ilo, ohi, olo;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_wide_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .stat0_i(stat0), .stat1_i(stat1), .ctl3_o(ctl3), .ctl4_o(ctl4),
    .iin_hi_o(ihi), .iin_lo_o(ilo), .iout_hi_o(ohi), .iout_lo_o(olo));

  int nchk = 0, nbad = 0, viol = 0;
  bit done = 0;
  string      exp_r[$];
  logic [7:0] exp_v[$];
  logic [7:0] act_v[$];

  task automatic expect_item(input string r, input logic [7:0] v);
    exp_r.push_back(r);
    exp_v.push_back(v);
  endtask

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    nchk++;
    if (a !== e) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", r, a, e);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (exp_v.size() > 0 && act_v.size() > 0) begin
      string r;
      logic [7:0] e, a;
      r = exp_r.pop_front();
      e = exp_v.pop_front();
      a = act_v.pop_front();
      chk(r, {56'h0, a}, {56'h0, e});
    end
  end

  logic oe_prev = 1'b0;
  initial forever begin
    @(negedge clk);
    if (sda_oe && !oe_prev && scl_m) viol++;
    oe_prev = sda_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  task automatic hq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b1; hq();
  endtask

  task automatic wbyte(input logic [7:0] b);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hq();
      scl_m = 1'b1; hq(); hq();
      scl_m = 1'b0; hq();
    end
    sda_m = 1'b1; hq();
    scl_m = 1'b1; hq();
    ack = ~sda_line; hq();
    scl_m = 1'b0; hq();
    act_v.push_back({7'd0, ack});
  endtask

  task automatic rbyte(input logic ack);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hq();
      scl_m = 1'b1; hq();
      b[i] = sda_line; hq();
      scl_m = 1'b0;
    end
    hq();
    sda_m = ~ack; hq();
    scl_m = 1'b1; hq(); hq();
    scl_m = 1'b0; hq();
    sda_m = 1'b1;
    act_v.push_back(b);
  endtask

  task automatic wr_seq(input logic [7:0] cmd, input logic [55:0] d, input int n,
                        input string r, input bit by_rstart);
    i2c_start();
    expect_item("R1", 8'd1); wbyte({A, 1'b0});
    expect_item("R3", 8'd1); wbyte(cmd);
    for (int i = 0; i < n; i++) begin
      expect_item(r, 8'd1);
      wbyte(d[8*i +: 8]);
    end
    if (by_rstart) i2c_rstart();
    i2c_stop();
  endtask

  task automatic rd_seq(input logic [7:0] cmd, input logic [55:0] d, input string r,
                        input bit chg, input logic [55:0] nv);
    i2c_start();
    expect_item("R1", 8'd1); wbyte({A, 1'b0});
    expect_item("R3", 8'd1); wbyte(cmd);
    i2c_rstart();
    expect_item("R1", 8'd1); wbyte({A, 1'b1});
    for (int i = 0; i < 7; i++) begin
      expect_item(r, d[8*i +: 8]);
      rbyte(i < 6);
      if (chg && i == 0) stat1 = nv;
    end
    i2c_stop();
  endtask

  localparam logic [55:0] D3 = 56'h11223344556677;
  localparam logic [55:0] D4 = 56'hC0FFEE0BADF00D;
  localparam logic [55:0] D5 = {16'hBEEF, 10'h001, 10'h3FF, 10'h15A, 10'h2A5};

  initial begin
    repeat (5) @(negedge clk);
    chk("R11", {63'd0, sda_oe}, 64'd0);
    chk("R11", {8'd0, ctl3}, 64'd0);
    chk("R11", {8'd0, ctl4}, 64'd0);
    chk("R11", {24'd0, ihi, ilo, ohi, olo}, 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    wr_seq(8'hE3, D3, 7, "R4", 0);
    chk("R4", {8'd0, ctl3}, {8'd0, D3});
    rd_seq(8'hE3, D3, "R7", 0, '0);

    wr_seq(8'hE5, D5, 7, "R9", 0);
    chk("R9", {54'd0, ihi}, 64'h2A5);
    chk("R9", {54'd0, ilo}, 64'h15A);
    chk("R9", {54'd0, ohi}, 64'h3FF);
    chk("R9", {54'd0, olo}, 64'h001);
    rd_seq(8'hE5, D5, "R7", 0, '0);

    wr_seq(8'hE4, D4, 6, "R5", 0);
    chk("R5", {8'd0, ctl4}, 64'd0);
    wr_seq(8'hE4, D4, 7, "R4", 0);
    chk("R4", {8'd0, ctl4}, {8'd0, D4});
    wr_seq(8'hE4, 56'h0, 3, "R5", 1);
    chk("R5", {8'd0, ctl4}, {8'd0, D4});

    i2c_start();
    expect_item("R1", 8'd1); wbyte({A, 1'b0});
    expect_item("R3", 8'd1); wbyte(8'hE0);
    expect_item("R6", 8'd0); wbyte(8'h55);
    i2c_stop();
    chk("R6", {8'd0, ctl3}, {8'd0, D3});
    chk("R6", {8'd0, ctl4}, {8'd0, D4});
    rd_seq(8'hE0, stat0, "R6", 0, '0);

    i2c_start();
    expect_item("R1", 8'd1); wbyte({A, 1'b0});
    expect_item("R3", 8'd0); wbyte(8'hE2);
    i2c_stop();
    i2c_start();
    expect_item("R1", 8'd1); wbyte({A, 1'b0});
    expect_item("R3", 8'd0); wbyte(8'hE6);
    i2c_stop();

    i2c_start();
    expect_item("R1", 8'd0); wbyte({4'h5, 3'd4, 1'b0});
    i2c_stop();
    strap = 3'd0;
    repeat (5) @(negedge clk);
    i2c_start();
    expect_item("R2", 8'd0); wbyte({4'h5, 3'd0, 1'b0});
    i2c_stop();
    strap = 3'd3;
    repeat (5) @(negedge clk);

    rd_seq(8'hE1, 56'h0F1E2D3C4B5A69, "R8", 1, 56'h99887766554433);
    rd_seq(8'hE1, 56'h99887766554433, "R8", 0, '0);

    chk("R10", 64'(viol), 64'd0);
    repeat (20) @(negedge clk);
    chk("R7", 64'(act_v.size()), 64'(exp_v.size()));
    report();
  end
endmodule